// File: doc/BRIEF.md
# Restricted PCI Target Interface

This block is the target-only front end of a 32-bit PCI agent. It watches the shared bus and takes part only in the small set of transactions needed to reach a memory-mapped register or memory region behind it. It also answers type-0 configuration cycles for its own 128-byte configuration window. In the address phase it classifies the command. The cache-oriented read and write variants are folded onto plain memory reads and writes. I/O, interrupt-acknowledge, special and dual-address commands are left unclaimed.

Claimed memory data phases are passed to a simple word-wide backend port made of a word address, write data, byte enables and one-cycle read and write strobes. Read data from the backend is returned on the bus without wait states. A burst whose starting address is not word-aligned in its low two bits is cut to one data phase by a disconnect. Configuration accesses are always single-phase.

The on-chip configuration space holds three registers:
- an identity word at offset 0x00;
- a command word at offset 0x04, whose bit 1 enables memory decode;
- one memory base address register at offset 0x10, whose window size is set by a parameter.

Top module: `pci_tgt_lite`

## Requirements
- R1: A memory read (0110) or memory write (0111) is claimed only when the memory enable bit (bit 1 of the configuration word at 0x04) is set and address bits [31:BAR_BITS] equal the base register; otherwise DEVSEL# stays high.
- R2: Decode is medium speed. If FRAME# is first sampled low at clock edge k, DEVSEL# and TRDY# go low after edge k+1 and never after edge k. TRDY# is low only while DEVSEL# is low.
- R3: Memory Read Multiple (1100) and Memory Read Line (1110) behave exactly as a memory read. Memory Write and Invalidate (1111) behaves exactly as a memory write.
- R4: Interrupt Acknowledge (0000), Special Cycle (0001), I/O Read (0010), I/O Write (0011) and Dual Address Cycle (1101) are never claimed and never write the backend.
- R5: With AD[1:0]=00 in the address phase, a memory burst runs until the master ends it. Data phase n uses word address base+n, which is the byte address plus 4 per phase, and STOP# stays high.
- R6: With AD[1:0]≠00 in a claimed memory address phase, the first data phase completes with STOP# low together with TRDY#. No further data phase completes.
- R7: Configuration read (1010) and write (1011) are claimed when IDSEL is high and AD[1:0]=00. Each completes one data phase and disconnects. Offsets 0x80–0xFC read zero, and writes there change nothing.
- R8: Offset 0x00 reads {DEV_ID, VEN_ID}. Offset 0x10 is the base register: bits [31:BAR_BITS] are writable and the lower bits read zero, so writing all ones reads back the window size mask.
- R9: During a write data phase, C/BE#[n] low enables byte lane n (bits 8n+7:8n). Lanes with C/BE# high keep their old contents.
- R10: One clock after every clock in which the block drives AD, par_out equals the XOR of the AD and C/BE# values of that clock, and par_oe is high.
- R11: During and after reset, with no transaction, DEVSEL#, TRDY# and STOP# are high, and ctl_oe and ad_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME# sampled from the bus |
| irdy_n | input | 1 | IRDY# sampled from the bus |
| idsel | input | 1 | Configuration select |
| ad_in | input | 32 | AD sampled from the bus |
| cbe_n | input | 4 | C/BE# sampled from the bus |
| ad_out | output | 32 | Read data to drive onto AD |
| ad_oe | output | 1 | AD output enable |
| par_out | output | 1 | PAR value |
| par_oe | output | 1 | PAR output enable |
| devsel_n | output | 1 | DEVSEL# value |
| trdy_n | output | 1 | TRDY# value |
| stop_n | output | 1 | STOP# value |
| ctl_oe | output | 1 | Enable for DEVSEL#, TRDY#, STOP# |
| be_addr | output | BAR_BITS-2 | Backend word address within the window |
| be_wdata | output | 32 | Backend write data |
| be_wbe | output | 4 | Backend byte enables, active high |
| be_wr | output | 1 | Backend write strobe, one per completed write phase |
| be_rd | output | 1 | Backend read strobe, one per completed read phase |
| be_rdata | input | 32 | Backend read data for be_addr, same cycle |

## Verification
Memory traffic is tried with four-word aligned bursts in both directions, which show that the word address advances per phase and that no early stop occurs. The same traffic is then repeated with each aliased command code, which shows the aliases have no side path of their own. Misaligned starting addresses, partial byte enables and unsupported command codes aimed at a live window separate a disconnect from a full burst, a merged write from a whole-word write, and silence from a claim. Configuration cycles to the identity, base and out-of-window offsets, together with an all-ones base write, separate a real register from the zero fill. The cycle of the first DEVSEL# and the parity one clock after read data confirm the medium-decode and parity timing.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_MRD, K_MWR, K_CRD, K_CWR
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_DATA, S_STOPW, S_TURN, S_IGN
  } state_e;

  // Fold the command code onto the four kinds the target serves.
  function automatic kind_e classify(input logic [3:0] cmd);
    case (cmd)
      4'b0110, 4'b1100, 4'b1110: classify = K_MRD;
      4'b0111, 4'b1111:          classify = K_MWR;
      4'b1010:                   classify = K_CRD;
      4'b1011:                   classify = K_CWR;
      default:                   classify = K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pci_tgt_cmd_dec.sv
module pci_tgt_cmd_dec
  import pci_tgt_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic [1:0] ad_lo,
  input  logic       idsel,
  input  logic       bar_match,
  input  logic       mem_en,
  output kind_e      kind,
  output logic       claim,
  output logic       single
);

  logic is_mem, is_cfg;

  always_comb begin
    kind   = classify(cmd);
    is_mem = (kind == K_MRD) || (kind == K_MWR);
    is_cfg = (kind == K_CRD) || (kind == K_CWR);
    claim  = (is_mem && mem_en && bar_match) ||
             (is_cfg && idsel && (ad_lo == 2'b00));
    single = is_cfg || (ad_lo != 2'b00);
  end

endmodule

// File: rtl/pci_tgt_cfg.sv
module pci_tgt_cfg #(
  parameter int             BAR_BITS = 12,
  parameter logic [15:0]    VEN_ID   = 16'h1D0F,
  parameter logic [15:0]    DEV_ID   = 16'h0A51
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [5:0]          idx,
  input  logic [3:0]          wbe,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [31-BAR_BITS:0] bar_hi,
  output logic                mem_en
);

  localparam logic [5:0]  IDX_ID   = 6'd0;
  localparam logic [5:0]  IDX_CMD  = 6'd1;
  localparam logic [5:0]  IDX_BAR  = 6'd4;
  localparam logic [31:0] BAR_MASK = ~((32'h1 << BAR_BITS) - 32'h1);

  logic [31:0] bar_q, bar_d, bar_wr;
  logic        men_q, men_d;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign bar_wr[8*b +: 8] = (we && idx == IDX_BAR && wbe[b]) ?
                              wdata[8*b +: 8] : bar_q[8*b +: 8];
  end

  always_comb begin
    bar_d = bar_wr & BAR_MASK;
    men_d = (we && idx == IDX_CMD && wbe[0]) ? wdata[1] : men_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q <= '0;
      men_q <= 1'b0;
    end else begin
      bar_q <= bar_d;
      men_q <= men_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_ID:  rdata = {DEV_ID, VEN_ID};
      IDX_CMD: rdata = {30'd0, men_q, 1'b0};
      IDX_BAR: rdata = bar_q;
      default: rdata = '0;
    endcase
  end

  assign bar_hi = bar_q[31:BAR_BITS];
  assign mem_en = men_q;

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic claim,
  input  logic single,
  output logic addr_phase,
  output logic complete,
  output logic in_data,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic ctl_oe
);

  state_e st_q, st_d;
  logic   frame_q, hit_q, hit_d, disc_q, disc_d;

  assign addr_phase = (st_q == S_IDLE) && !frame_n && frame_q;
  assign in_data    = (st_q == S_DATA);
  assign complete   = in_data && !irdy_n;

  always_comb begin
    st_d   = st_q;
    hit_d  = addr_phase ? claim  : hit_q;
    disc_d = addr_phase ? single : disc_q;
    case (st_q)
      S_IDLE:  if (addr_phase) st_d = S_DEC;
      S_DEC:   st_d = hit_q ? S_DATA : S_IGN;
      S_DATA:  if (complete) begin
                 if (frame_n)     st_d = S_TURN;
                 else if (disc_q) st_d = S_STOPW;
               end
      S_STOPW: if (frame_n) st_d = S_TURN;
      S_TURN:  st_d = S_IDLE;
      S_IGN:   if (frame_n && irdy_n) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      frame_q <= 1'b1;
      hit_q   <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_n;
      hit_q   <= hit_d;
      disc_q  <= disc_d;
    end
  end

  always_comb begin
    devsel_n = !((st_q == S_DATA) || (st_q == S_STOPW));
    trdy_n   = !(st_q == S_DATA);
    stop_n   = !(((st_q == S_DATA) && disc_q) || (st_q == S_STOPW));
    ctl_oe   = (st_q == S_DATA) || (st_q == S_STOPW) || (st_q == S_TURN);
  end

endmodule

// File: rtl/pci_tgt_lite.sv
module pci_tgt_lite
  import pci_tgt_pkg::*;
#(
  parameter int          BAR_BITS = 12,
  parameter logic [15:0] VEN_ID   = 16'h1D0F,
  parameter logic [15:0] DEV_ID   = 16'h0A51
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic                 idsel,
  input  logic [31:0]          ad_in,
  input  logic [3:0]           cbe_n,
  output logic [31:0]          ad_out,
  output logic                 ad_oe,
  output logic                 par_out,
  output logic                 par_oe,
  output logic                 devsel_n,
  output logic                 trdy_n,
  output logic                 stop_n,
  output logic                 ctl_oe,
  output logic [BAR_BITS-3:0]  be_addr,
  output logic [31:0]          be_wdata,
  output logic [3:0]           be_wbe,
  output logic                 be_wr,
  output logic                 be_rd,
  input  logic [31:0]          be_rdata
);

  localparam int AW = BAR_BITS - 2;

  logic [1:0]          rs_q;
  logic                rst_sn;
  logic [AW-1:0]       addr_q, addr_d;
  kind_e               kind, kind_q, kind_d;
  logic                claim, single, addr_phase, complete, in_data;
  logic                mem_en, cfg_we, bar_match, rd_kind;
  logic [31-BAR_BITS:0] bar_hi;
  logic [31:0]         cfg_rdata, rd_word;
  logic                par_d, par_q, poe_q;

  // Reset enters at once, leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign bar_match = (ad_in[31:BAR_BITS] == bar_hi);

  pci_tgt_cmd_dec u_dec (
    .cmd(cbe_n), .ad_lo(ad_in[1:0]), .idsel(idsel), .bar_match(bar_match),
    .mem_en(mem_en), .kind(kind), .claim(claim), .single(single)
  );

  pci_tgt_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .frame_n(frame_n), .irdy_n(irdy_n),
    .claim(claim), .single(single), .addr_phase(addr_phase),
    .complete(complete), .in_data(in_data), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe)
  );

  pci_tgt_cfg #(.BAR_BITS(BAR_BITS), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID)) u_cfg (
    .clk(clk), .rst_n(rst_sn), .we(cfg_we), .idx(addr_q[5:0]),
    .wbe(~cbe_n), .wdata(ad_in), .rdata(cfg_rdata), .bar_hi(bar_hi),
    .mem_en(mem_en)
  );

  // Address counter: load on address phase, step one word per data phase.
  always_comb begin
    addr_d = addr_q;
    kind_d = kind_q;
    if (addr_phase) begin
      addr_d = ad_in[BAR_BITS-1:2];
      kind_d = kind;
    end else if (complete) begin
      addr_d = addr_q + AW'(1);
    end
  end

  always_comb begin
    rd_kind  = (kind_q == K_MRD) || (kind_q == K_CRD);
    rd_word  = (kind_q == K_MRD) ? be_rdata : cfg_rdata;
    ad_oe    = in_data && rd_kind;
    ad_out   = ad_oe ? rd_word : '0;
    be_addr  = addr_q;
    be_wdata = ad_in;
    be_wbe   = ~cbe_n;
    be_wr    = complete && (kind_q == K_MWR);
    be_rd    = complete && (kind_q == K_MRD);
    cfg_we   = complete && (kind_q == K_CWR);
    par_d    = ^{ad_out, cbe_n};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      addr_q <= '0;
      kind_q <= K_NONE;
      par_q  <= 1'b0;
      poe_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      kind_q <= kind_d;
      par_q  <= par_d;
      poe_q  <= ad_oe;
    end
  end

  assign par_out = par_q;
  assign par_oe  = poe_q;

endmodule

// File: rtl/pci_tgt_lite_chk.sv
module pci_tgt_lite_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic [3:0] cbe_n,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       ad_oe,
  input logic       par_oe,
  input logic       be_wr
);

  logic unsup;
  assign unsup = (cbe_n == 4'b0000) || (cbe_n == 4'b0001) ||
                 (cbe_n == 4'b0010) || (cbe_n == 4'b0011) ||
                 (cbe_n == 4'b1101);

  AST_MEDIUM_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |=> devsel_n);                                   // R2
  AST_TRDY_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);                                         // R2
  AST_UNSUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && unsup) |=> devsel_n ##1 devsel_n);           // R4
  AST_STOP_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n);                                         // R6
  AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && !stop_n) |=> trdy_n);                    // R6
  AST_WR_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    be_wr |-> (!irdy_n && !trdy_n));                                // R9
  AST_PAR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> $past(ad_oe));                                       // R10

endmodule

bind pci_tgt_lite pci_tgt_lite_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
  .ad_oe(ad_oe), .par_oe(par_oe), .be_wr(be_wr)
);

// File: tb/pci_tgt_lite_bench.sv
module pci_tgt_lite_bench;

  localparam int          BAR_BITS = 12;
  localparam logic [31:0] BASE     = 32'h4000_0000;

  logic        clk, rst_n, frame_n, irdy_n, idsel;
  logic [31:0] ad_in, ad_out, be_wdata, be_rdata;
  logic [3:0]  cbe_n, be_wbe;
  logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, ctl_oe;
  logic        be_wr, be_rd;
  logic [BAR_BITS-3:0] be_addr;

  int checks = 0, errors = 0;
  logic [31:0] mem [1024];
  logic [31:0] wbuf [8];
  logic [31:0] rbuf [8];
  int  x_done, x_dev;
  bit  x_stop, p_exp, p_got, p_oe;

  pci_tgt_lite #(.BAR_BITS(BAR_BITS)) u_pci_tgt_lite (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .idsel(idsel), .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_wbe(be_wbe), .be_wr(be_wr), .be_rd(be_rd),
    .be_rdata(be_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Backend model: word memory with byte-lane writes.
  assign be_rdata = mem[be_addr];
  always @(posedge clk)
    if (be_wr)
      for (int b = 0; b < 4; b++)
        if (be_wbe[b]) mem[be_addr][8*b +: 8] <= be_wdata[8*b +: 8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Master transaction: n data phases, write data from wbuf, read data to rbuf.
  task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                      input bit sel, input logic [3:0] ben);
    bit wr, comp, st;
    wr = cmd[0];
    x_done = 0; x_stop = 0; x_dev = -1;
    @(negedge clk);
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(negedge clk);
    idsel = 1'b0; irdy_n = 1'b0; frame_n = (n == 1); cbe_n = ~ben;
    ad_in = wr ? wbuf[0] : 32'h0;
    for (int c = 0; c < 40; c++) begin
      comp = !trdy_n;
      st   = !stop_n;
      if (!devsel_n && x_dev < 0) x_dev = c;
      if (comp) begin
        if (!wr) rbuf[x_done] = ad_out;
        p_exp = ^{ad_out, cbe_n};
        x_done++;
      end
      if (st) x_stop = 1;
      @(negedge clk);
      if (comp) begin p_got = par_out; p_oe = par_oe; end
      if ((comp || st) && frame_n) begin irdy_n = 1'b1; break; end
      if (st) begin frame_n = 1'b1; continue; end
      if (comp) begin
        ad_in = wr ? wbuf[x_done] : 32'h0;
        frame_n = (x_done == n - 1);
      end
    end
    idle(2);
  endtask

  // Single phase that nobody should claim; returns 1 if any claim was seen.
  task automatic miss(input logic [3:0] cmd, input logic [31:0] addr,
                      input logic [31:0] data, output bit seen);
    seen = 0;
    @(negedge clk);
    frame_n = 1'b0; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; ad_in = data; cbe_n = 4'b0000;
    repeat (6) begin
      @(negedge clk);
      if (!devsel_n || !trdy_n || be_wr) seen = 1;
    end
    irdy_n = 1'b1;
    idle(2);
  endtask

  task automatic cfg_rd(input logic [7:0] off, output logic [31:0] v);
    xfer(4'b1010, {24'h0, off}, 1, 1'b1, 4'hF);
    v = rbuf[0];
  endtask

  task automatic cfg_wr(input logic [7:0] off, input logic [31:0] v, input logic [3:0] ben);
    wbuf[0] = v;
    xfer(4'b1011, {24'h0, off}, 1, 1'b1, ben);
  endtask

  task automatic t_reset;
    chk("R11 devsel_n", devsel_n, 1);
    chk("R11 trdy_n", trdy_n, 1);
    chk("R11 stop_n", stop_n, 1);
    chk("R11 ctl_oe", ctl_oe, 0);
    chk("R11 ad_oe", ad_oe, 0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    bit seen;
    cfg_rd(8'h00, v);
    chk("R8 identity word", v, 32'h0A51_1D0F);
    chk("R7 config single phase", x_done, 1);
    chk("R7 config disconnect", x_stop, 1);
    cfg_wr(8'h80, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(8'h80, v);
    chk("R7 offset 0x80 reads zero", v, 0);
    cfg_rd(8'h10, v);
    chk("R7 write above window no effect", v, 0);
    cfg_wr(8'h10, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(8'h10, v);
    chk("R8 base sizing mask", v, 32'hFFFF_F000);
    cfg_wr(8'h10, BASE, 4'hF);
    cfg_rd(8'h10, v);
    chk("R8 base readback", v, BASE);
    miss(4'b0110, BASE, 0, seen);
    chk("R1 no claim while memory disabled", seen, 0);
    cfg_wr(8'h04, 32'h2, 4'b0001);
    cfg_rd(8'h04, v);
    chk("R1 memory enable bit", v, 32'h2);
  endtask

  task automatic t_burst;
    for (int i = 0; i < 4; i++) wbuf[i] = 32'hA000_0000 + i * 32'h1111;
    xfer(4'b0111, BASE + 32'h20, 4, 1'b0, 4'hF);
    chk("R5 write burst phases", x_done, 4);
    chk("R5 write burst no stop", x_stop, 0);
    xfer(4'b0110, BASE + 32'h20, 4, 1'b0, 4'hF);
    chk("R5 read burst phases", x_done, 4);
    chk("R2 devsel on second clock", x_dev, 1);
    for (int i = 0; i < 4; i++) chk("R5 burst word", rbuf[i], 32'hA000_0000 + i * 32'h1111);
    chk("R1 backend word 8", mem[8], 32'hA000_0000);
  endtask

  task automatic t_alias;
    xfer(4'b1110, BASE + 32'h24, 2, 1'b0, 4'hF);
    chk("R3 read line phases", x_done, 2);
    chk("R3 read line data", rbuf[1], 32'hA000_2222);
    xfer(4'b1100, BASE + 32'h2C, 1, 1'b0, 4'hF);
    chk("R3 read multiple data", rbuf[0], 32'hA000_3333);
    wbuf[0] = 32'h5A5A_0F0F;
    xfer(4'b1111, BASE + 32'h30, 1, 1'b0, 4'hF);
    xfer(4'b0110, BASE + 32'h30, 1, 1'b0, 4'hF);
    chk("R3 write invalidate stored", rbuf[0], 32'h5A5A_0F0F);
  endtask

  task automatic t_unsup;
    bit seen;
    logic [3:0] codes [5] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b1101};
    for (int i = 0; i < 5; i++) begin
      miss(codes[i], BASE + 32'h20, 32'hDEAD_BEEF, seen);
      chk($sformatf("R4 unclaimed code %b", codes[i]), seen, 0);
    end
    xfer(4'b0110, BASE + 32'h20, 1, 1'b0, 4'hF);
    chk("R4 no backend write from I/O", rbuf[0], 32'hA000_0000);
    miss(4'b0110, 32'h5000_0020, 0, seen);
    chk("R1 address outside window", seen, 0);
  endtask

  task automatic t_nonlin;
    xfer(4'b0110, BASE + 32'h21, 4, 1'b0, 4'hF);
    chk("R6 misaligned read one phase", x_done, 1);
    chk("R6 misaligned read stop", x_stop, 1);
    chk("R6 misaligned read data", rbuf[0], 32'hA000_0000);
    wbuf[0] = 32'h1234_5678; wbuf[1] = 32'h8765_4321; wbuf[2] = 32'h1;
    xfer(4'b0111, BASE + 32'h42, 3, 1'b0, 4'hF);
    chk("R6 misaligned write one phase", x_done, 1);
    xfer(4'b0110, BASE + 32'h40, 2, 1'b0, 4'hF);
    chk("R6 first word written", rbuf[0], 32'h1234_5678);
    chk("R6 second word untouched", rbuf[1], 32'h0);
  endtask

  task automatic t_bytes;
    wbuf[0] = 32'hAABB_CCDD;
    xfer(4'b0111, BASE + 32'h50, 1, 1'b0, 4'hF);
    wbuf[0] = 32'h1122_3344;
    xfer(4'b0111, BASE + 32'h50, 1, 1'b0, 4'b0101);
    xfer(4'b0110, BASE + 32'h50, 1, 1'b0, 4'hF);
    chk("R9 lanes 0 and 2 merged", rbuf[0], 32'hAA22_CC44);
  endtask

  task automatic t_parity;
    xfer(4'b0110, BASE + 32'h50, 1, 1'b0, 4'b0110);
    chk("R10 parity value", p_got, p_exp);
    chk("R10 parity enable", p_oe, 1);
    chk("R10 parity matches data", p_exp, ^{32'hAA22_CC44, 4'b1001});
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
    ad_in = 32'h0; cbe_n = 4'hF;
    idle(4);
    t_reset;
    rst_n = 1'b1;
    idle(5);
    t_reset;
    t_config;
    t_burst;
    t_alias;
    t_unsup;
    t_nonlin;
    t_bytes;
    t_parity;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule